// File: doc/BRIEF.md
# Tile Partial-Beam Coefficient Multiplier

This block forms partial beams for one tile of antenna elements. On each accepted sample time it gathers a complex element vector from a wider set of antenna streams, multiplies that vector by a beam-by-element complex weight matrix, and emits one complex partial sum per beam. This is the only stage in the beamforming chain that applies weights. Every stage after it only adds, so each output is a finished weighted partial sum that a cross-tile adder can combine directly.

The element vector is assembled by a programmable slot map. Each vector slot holds the index of the antenna stream that feeds it. Weights are written into a shadow bank through their own port and take effect only when a commit strobe swaps them in on a sample boundary. Each beam's weights are independent, so beams can point anywhere. Beams are computed one per clock. A sample therefore occupies the block for a fixed N_BEAM clocks plus one idle clock, during which a valid/ready handshake holds off the next sample.

Top module: `pbf_mult_node`

## Requirements
- R1: Each antenna sample is 8 bits, with a signed two's-complement real part in bits [7:4] and a signed imaginary part in bits [3:0]. Antenna a occupies ant_data_i[8a+7:8a]. A weight is 2*COEF_W bits, with its signed real part in the upper COEF_W bits and its signed imaginary part in the lower COEF_W bits.
- R2: For beam b the outputs are out_re_o = sum over e of (wr[b][e]*vr[e] - wi[b][e]*vi[e]) and out_im_o = sum over e of (wr[b][e]*vi[e] + wi[b][e]*vr[e]). The sums are kept at full precision in ACC_W = 4+COEF_W+1+ceil(log2(N_ELEM)) bits and never wrap, including at the extreme input and weight values.
- R3: Vector slot s takes antenna stream sel[s]. After reset, sel[s] = s. A slot-map write changes the routing for every sample accepted after the write cycle.
- R4: A sample is accepted in a cycle where in_valid_i and in_ready_o are both high. Beams 0 to N_BEAM-1 then appear with out_valid_o high on consecutive cycles, starting two cycles after the accept. in_ready_o is low from the cycle after the accept until it rises again in the cycle that shows the last beam.
- R5: After reset, in_ready_o is high, out_valid_o is low and every weight is zero. Outputs are therefore zero until a commit has taken place.
- R6: A weight write changes only the shadow bank. Outputs keep using the committed weights until coef_commit_i is pulsed.
- R7: A commit pulsed while a sample is in progress is held until that sample's last beam has been issued. Every beam of the in-progress sample uses the old weights, and the next sample uses the new ones.
- R8: Writing and committing the weight at (beam b, element e) changes the output of beam b only.
- R9: Changes on ant_data_i while in_ready_o is low have no effect on the outputs of the sample in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ant_data_i | input | 8*N_ANT | Antenna sample streams, 8 bits each |
| in_valid_i | input | 1 | Sample vector valid |
| in_ready_o | output | 1 | Block can accept a sample |
| sel_we_i | input | 1 | Slot-map write strobe |
| sel_slot_i | input | SLOT_W | Slot being written |
| sel_ant_i | input | ANT_W | Antenna index for that slot |
| coef_we_i | input | 1 | Shadow weight write strobe |
| coef_beam_i | input | BEAM_W | Beam index of the weight |
| coef_elem_i | input | SLOT_W | Element index of the weight |
| coef_data_i | input | 2*COEF_W | Complex weight {re, im} |
| coef_commit_i | input | 1 | Swap the shadow bank in at the next sample boundary |
| out_valid_o | output | 1 | Partial sum valid |
| out_beam_o | output | BEAM_W | Beam index of the partial sum |
| out_re_o | output | ACC_W | Real part of the partial sum |
| out_im_o | output | ACC_W | Imaginary part of the partial sum |

## Verification
The checks assume that the slot map holds only antenna indices below N_ANT, and that writes and commits are single-cycle pulses. They also assume that the zero-output property is enforced only until the first commit pulse. The bench writes only valid antenna indices and pulses each control for exactly one cycle. It writes weights only while the block is idle, except in the deferred-commit scenario, where the commit is deliberately raised during a busy cycle. The scramble scenario alters ant_data_i only while in_ready_o is low, and it restores the data before the next handshake.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
  localparam int unsigned SMP_W = 4;
  localparam int unsigned SMP_BITS = 2 * SMP_W;

  typedef struct packed {
    logic signed [SMP_W-1:0] re;
    logic signed [SMP_W-1:0] im;
  } smp_t;
endpackage

// File: rtl/pbf_sel_map.sv
module pbf_sel_map #(
  parameter int unsigned N_ANT  = 8,
  parameter int unsigned N_ELEM = 4,
  localparam int unsigned ANT_W  = (N_ANT  > 1) ? $clog2(N_ANT)  : 1,
  localparam int unsigned SLOT_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int unsigned SB     = pbf_pkg::SMP_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [SLOT_W-1:0]     slot_i,
  input  logic [ANT_W-1:0]      ant_i,
  input  logic [N_ANT*SB-1:0]   ant_data_i,
  output logic [N_ELEM*SB-1:0]  elem_o
);
  logic [ANT_W-1:0] sel_q [N_ELEM];
  pbf_pkg::smp_t    ant_arr [N_ANT];

  for (genvar a = 0; a < N_ANT; a++) begin : g_unpack
    assign ant_arr[a] = ant_data_i[a*SB +: SB];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_ELEM; s++) sel_q[s] <= ANT_W'(s % N_ANT);
    end else if (we_i) begin
      sel_q[slot_i] <= ant_i;
    end
  end

  for (genvar s = 0; s < N_ELEM; s++) begin : g_route
    assign elem_o[s*SB +: SB] = ant_arr[sel_q[s]];
  end
endmodule

// File: rtl/pbf_coef_bank.sv
module pbf_coef_bank #(
  parameter int unsigned N_ELEM = 4,
  parameter int unsigned N_BEAM = 4,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned SLOT_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int unsigned BEAM_W = (N_BEAM > 1) ? $clog2(N_BEAM) : 1,
  localparam int unsigned CW2    = 2 * COEF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [BEAM_W-1:0]       beam_i,
  input  logic [SLOT_W-1:0]       elem_i,
  input  logic [CW2-1:0]          data_i,
  input  logic                    apply_i,
  input  logic [BEAM_W-1:0]       rd_beam_i,
  output logic [N_ELEM*CW2-1:0]   row_o
);
  logic [CW2-1:0] shadow_q [N_BEAM][N_ELEM];
  logic [CW2-1:0] active_q [N_BEAM][N_ELEM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < N_BEAM; b++)
        for (int e = 0; e < N_ELEM; e++) shadow_q[b][e] <= '0;
    end else if (we_i) begin
      shadow_q[beam_i][elem_i] <= data_i;
    end
  end

  // active bank only moves on a sample boundary (apply_i)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < N_BEAM; b++)
        for (int e = 0; e < N_ELEM; e++) active_q[b][e] <= '0;
    end else if (apply_i) begin
      active_q <= shadow_q;
    end
  end

  for (genvar e = 0; e < N_ELEM; e++) begin : g_row
    assign row_o[e*CW2 +: CW2] = active_q[rd_beam_i][e];
  end
endmodule

// File: rtl/pbf_beam_mac.sv
module pbf_beam_mac #(
  parameter int unsigned N_ELEM = 4,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned ACC_W  = 15,
  localparam int unsigned SB     = pbf_pkg::SMP_BITS,
  localparam int unsigned CW2    = 2 * COEF_W,
  localparam int unsigned PROD_W = pbf_pkg::SMP_W + COEF_W
) (
  input  logic [N_ELEM*SB-1:0]    elem_i,
  input  logic [N_ELEM*CW2-1:0]   row_i,
  output logic signed [ACC_W-1:0] re_o,
  output logic signed [ACC_W-1:0] im_o
);
  pbf_pkg::smp_t            smp [N_ELEM];
  logic signed [COEF_W-1:0] wr  [N_ELEM];
  logic signed [COEF_W-1:0] wi  [N_ELEM];
  logic signed [PROD_W-1:0] p_rr [N_ELEM];
  logic signed [PROD_W-1:0] p_ii [N_ELEM];
  logic signed [PROD_W-1:0] p_ri [N_ELEM];
  logic signed [PROD_W-1:0] p_ir [N_ELEM];

  for (genvar e = 0; e < N_ELEM; e++) begin : g_prod
    assign smp[e]  = elem_i[e*SB +: SB];
    assign wr[e]   = row_i[e*CW2+COEF_W +: COEF_W];
    assign wi[e]   = row_i[e*CW2 +: COEF_W];
    assign p_rr[e] = wr[e] * smp[e].re;
    assign p_ii[e] = wi[e] * smp[e].im;
    assign p_ri[e] = wr[e] * smp[e].im;
    assign p_ir[e] = wi[e] * smp[e].re;
  end

  always_comb begin
    re_o = '0;
    im_o = '0;
    for (int e = 0; e < N_ELEM; e++) begin
      re_o = re_o + ACC_W'(p_rr[e]) - ACC_W'(p_ii[e]);
      im_o = im_o + ACC_W'(p_ri[e]) + ACC_W'(p_ir[e]);
    end
  end
endmodule

// File: rtl/pbf_mult_node.sv
module pbf_mult_node #(
  parameter int unsigned N_ANT  = 8,
  parameter int unsigned N_ELEM = 4,
  parameter int unsigned N_BEAM = 4,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned ANT_W  = (N_ANT  > 1) ? $clog2(N_ANT)  : 1,
  localparam int unsigned SLOT_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int unsigned BEAM_W = (N_BEAM > 1) ? $clog2(N_BEAM) : 1,
  localparam int unsigned LOG_E  = (N_ELEM > 1) ? $clog2(N_ELEM) : 0,
  localparam int unsigned ACC_W  = pbf_pkg::SMP_W + COEF_W + 1 + LOG_E,
  localparam int unsigned SB     = pbf_pkg::SMP_BITS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_ANT*SB-1:0]      ant_data_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic                     sel_we_i,
  input  logic [SLOT_W-1:0]        sel_slot_i,
  input  logic [ANT_W-1:0]         sel_ant_i,
  input  logic                     coef_we_i,
  input  logic [BEAM_W-1:0]        coef_beam_i,
  input  logic [SLOT_W-1:0]        coef_elem_i,
  input  logic [2*COEF_W-1:0]      coef_data_i,
  input  logic                     coef_commit_i,
  output logic                     out_valid_o,
  output logic [BEAM_W-1:0]        out_beam_o,
  output logic signed [ACC_W-1:0]  out_re_o,
  output logic signed [ACC_W-1:0]  out_im_o
);
  logic                      busy_q, pend_q, accept, apply, last;
  logic [BEAM_W-1:0]         bcnt_q;
  logic [N_ELEM*SB-1:0]      elem_vec, elem_q;
  logic [N_ELEM*2*COEF_W-1:0] row;
  logic signed [ACC_W-1:0]   mac_re, mac_im;

  assign in_ready_o = !busy_q;
  assign accept     = in_valid_i && !busy_q;
  assign last       = (bcnt_q == BEAM_W'(N_BEAM - 1));
  // commit waits for an idle cycle so a sample never mixes banks
  assign apply      = !busy_q && (coef_commit_i || pend_q);

  pbf_sel_map #(.N_ANT(N_ANT), .N_ELEM(N_ELEM)) i_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (sel_we_i),
    .slot_i     (sel_slot_i),
    .ant_i      (sel_ant_i),
    .ant_data_i (ant_data_i),
    .elem_o     (elem_vec)
  );

  pbf_coef_bank #(.N_ELEM(N_ELEM), .N_BEAM(N_BEAM), .COEF_W(COEF_W)) i_coef (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (coef_we_i),
    .beam_i    (coef_beam_i),
    .elem_i    (coef_elem_i),
    .data_i    (coef_data_i),
    .apply_i   (apply),
    .rd_beam_i (bcnt_q),
    .row_o     (row)
  );

  pbf_beam_mac #(.N_ELEM(N_ELEM), .COEF_W(COEF_W), .ACC_W(ACC_W)) i_mac (
    .elem_i (elem_q),
    .row_i  (row),
    .re_o   (mac_re),
    .im_o   (mac_im)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bcnt_q <= '0;
      elem_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      bcnt_q <= '0;
      elem_q <= elem_vec;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      bcnt_q <= bcnt_q + BEAM_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= busy_q && (pend_q || coef_commit_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_beam_o  <= '0;
      out_re_o    <= '0;
      out_im_o    <= '0;
    end else begin
      out_valid_o <= busy_q;
      if (busy_q) begin
        out_beam_o <= bcnt_q;
        out_re_o   <= mac_re;
        out_im_o   <= mac_im;
      end
    end
  end
endmodule

// File: rtl/pbf_mult_node_chk.sv
module pbf_mult_node_chk #(
  parameter int unsigned N_BEAM = 4,
  parameter int unsigned ACC_W  = 15,
  localparam int unsigned BEAM_W = (N_BEAM > 1) ? $clog2(N_BEAM) : 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    in_ready_o,
  input logic                    coef_commit_i,
  input logic                    out_valid_o,
  input logic [BEAM_W-1:0]       out_beam_o,
  input logic signed [ACC_W-1:0] out_re_o,
  input logic signed [ACC_W-1:0] out_im_o
);
  logic seen_commit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            seen_commit_q <= 1'b0;
    else if (coef_commit_i) seen_commit_q <= 1'b1;
  end

  // R4
  accept_to_beam0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> ##1 (out_valid_o && out_beam_o == '0));

  // R4
  accept_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> !in_ready_o);

  // R4
  beam_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_beam_o != BEAM_W'(N_BEAM - 1)
    |=> out_valid_o && out_beam_o == $past(out_beam_o) + BEAM_W'(1));

  // R4
  ready_low_mid_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_beam_o != BEAM_W'(N_BEAM - 1) |-> !in_ready_o);

  // R5
  zero_before_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !seen_commit_q |-> out_re_o == '0 && out_im_o == '0);
endmodule

bind pbf_mult_node pbf_mult_node_chk #(.N_BEAM(N_BEAM), .ACC_W(ACC_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .coef_commit_i (coef_commit_i),
  .out_valid_o   (out_valid_o),
  .out_beam_o    (out_beam_o),
  .out_re_o      (out_re_o),
  .out_im_o      (out_im_o)
);

// File: tb/test_pbf_mult_node.sv
module test_pbf_mult_node;
  localparam int N_ANT = 8, N_ELEM = 4, N_BEAM = 4, COEF_W = 8, ACC_W = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                    rst_n;
  logic [N_ANT*8-1:0]      ant_data;
  logic                    in_valid, in_ready;
  logic                    sel_we;
  logic [1:0]              sel_slot;
  logic [2:0]              sel_ant;
  logic                    coef_we;
  logic [1:0]              coef_beam, coef_elem;
  logic [2*COEF_W-1:0]     coef_data;
  logic                    coef_commit;
  logic                    out_valid;
  logic [1:0]              out_beam;
  logic signed [ACC_W-1:0] out_re, out_im;

  pbf_mult_node i_pbf_mult_node (
    .clk_i(clk), .rst_ni(rst_n), .ant_data_i(ant_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .sel_we_i(sel_we), .sel_slot_i(sel_slot), .sel_ant_i(sel_ant),
    .coef_we_i(coef_we), .coef_beam_i(coef_beam), .coef_elem_i(coef_elem),
    .coef_data_i(coef_data), .coef_commit_i(coef_commit), .out_valid_o(out_valid),
    .out_beam_o(out_beam), .out_re_o(out_re), .out_im_o(out_im)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int sel_m [N_ELEM];
  int sh_re [N_BEAM][N_ELEM], sh_im [N_BEAM][N_ELEM];
  int ac_re [N_BEAM][N_ELEM], ac_im [N_BEAM][N_ELEM];
  int a_re [N_ANT], a_im [N_ANT];
  int seed = 12345;
  int prev_re [N_BEAM], prev_im [N_BEAM];
  int last_re [N_BEAM], last_im [N_BEAM];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(int lo, int hi);
    seed = seed * 1103515245 + 12345;
    return lo + ((seed >>> 8) & 32'h7fff) % (hi - lo + 1);
  endfunction

  task automatic drive_ant();
    for (int a = 0; a < N_ANT; a++) ant_data[a*8 +: 8] = {4'(a_re[a]), 4'(a_im[a])};
  endtask

  task automatic wr_coef(int b, int e, int re, int im);
    coef_we = 1; coef_beam = 2'(b); coef_elem = 2'(e); coef_data = {8'(re), 8'(im)};
    @(posedge clk); #1; coef_we = 0;
    sh_re[b][e] = re; sh_im[b][e] = im;
  endtask

  task automatic commit();
    coef_commit = 1; @(posedge clk); #1; coef_commit = 0;
    ac_re = sh_re; ac_im = sh_im;
  endtask

  task automatic wr_sel(int s, int a);
    sel_we = 1; sel_slot = 2'(s); sel_ant = 3'(a);
    @(posedge clk); #1; sel_we = 0;
    sel_m[s] = a;
  endtask

  // one sample: handshake, then beams checked against the model
  task automatic run_sample(string req, bit scramble, bit mid_commit);
    int er [N_BEAM], ei [N_BEAM];
    while (!in_ready) begin @(posedge clk); #1; end
    drive_ant();
    for (int b = 0; b < N_BEAM; b++) begin
      er[b] = 0; ei[b] = 0;
      for (int e = 0; e < N_ELEM; e++) begin
        er[b] += ac_re[b][e]*a_re[sel_m[e]] - ac_im[b][e]*a_im[sel_m[e]];
        ei[b] += ac_re[b][e]*a_im[sel_m[e]] + ac_im[b][e]*a_re[sel_m[e]];
      end
    end
    in_valid = 1; @(posedge clk); #1; in_valid = 0;
    chk("R4", "ready after accept", int'(in_ready), 0);
    chk("R4", "no output one cycle after accept", int'(out_valid), 0);
    if (scramble) ant_data = ~ant_data;
    if (mid_commit) coef_commit = 1;
    @(posedge clk); #1;
    coef_commit = 0;
    for (int b = 0; b < N_BEAM; b++) begin
      chk(req, "out_valid", int'(out_valid), 1);
      chk(req, "beam index", int'(out_beam), b);
      chk(req, $sformatf("beam %0d re", b), int'(out_re), er[b]);
      chk(req, $sformatf("beam %0d im", b), int'(out_im), ei[b]);
      chk("R4", "ready during beams", int'(in_ready), (b == N_BEAM-1) ? 1 : 0);
      last_re[b] = int'(out_re); last_im[b] = int'(out_im);
      if (b < N_BEAM-1) begin @(posedge clk); #1; end
    end
    @(posedge clk); #1;
    chk("R4", "out_valid after last beam", int'(out_valid), 0);
    if (mid_commit) begin ac_re = sh_re; ac_im = sh_im; end
    drive_ant();
  endtask

  task automatic rand_ant();
    for (int a = 0; a < N_ANT; a++) begin a_re[a] = rnd(-8, 7); a_im[a] = rnd(-8, 7); end
  endtask

  task automatic rand_coefs();
    for (int b = 0; b < N_BEAM; b++)
      for (int e = 0; e < N_ELEM; e++) wr_coef(b, e, rnd(-128, 127), rnd(-128, 127));
  endtask

  task automatic t_reset();
    chk("R5", "ready after reset", int'(in_ready), 1);
    chk("R5", "out_valid after reset", int'(out_valid), 0);
    chk("R5", "out_re after reset", int'(out_re), 0);
    rand_ant();
    run_sample("R5", 0, 0);
  endtask

  task automatic t_basic();
    rand_coefs(); commit();
    for (int k = 0; k < 4; k++) begin rand_ant(); run_sample("R2", 0, 0); end
    for (int a = 0; a < N_ANT; a++) begin a_re[a] = a - 4; a_im[a] = 3 - a; end
    run_sample("R1", 0, 0);
  endtask

  task automatic t_extremes();
    for (int b = 0; b < N_BEAM; b++)
      for (int e = 0; e < N_ELEM; e++) wr_coef(b, e, (b % 2) ? 127 : -128, (b < 2) ? 127 : -128);
    commit();
    for (int a = 0; a < N_ANT; a++) begin a_re[a] = -8; a_im[a] = 7; end
    run_sample("R2", 0, 0);
    for (int a = 0; a < N_ANT; a++) begin a_re[a] = -8; a_im[a] = -8; end
    run_sample("R2", 0, 0);
    chk("R2", "extreme beam 2 re", last_re[2], 4*(-128*-8 - -128*-8));
  endtask

  task automatic t_selector();
    rand_ant();
    wr_sel(0, 7); wr_sel(1, 5); wr_sel(2, 5); wr_sel(3, 0);
    run_sample("R3", 0, 0);
    for (int s = 0; s < N_ELEM; s++) wr_sel(s, 6);
    run_sample("R3", 0, 0);
    for (int s = 0; s < N_ELEM; s++) wr_sel(s, s + 4);
    rand_ant(); run_sample("R3", 0, 0);
  endtask

  task automatic t_shadow();
    rand_ant();
    run_sample("R6", 0, 0);
    prev_re = last_re; prev_im = last_im;
    rand_coefs();
    run_sample("R6", 0, 0);
    for (int b = 0; b < N_BEAM; b++) begin
      chk("R6", "uncommitted write no effect re", last_re[b], prev_re[b]);
      chk("R6", "uncommitted write no effect im", last_im[b], prev_im[b]);
    end
    commit();
    run_sample("R6", 0, 0);
  endtask

  task automatic t_defer();
    rand_ant();
    rand_coefs();
    run_sample("R7", 0, 1);
    run_sample("R7", 0, 0);
  endtask

  task automatic t_beam_indep();
    rand_ant();
    run_sample("R8", 0, 0);
    prev_re = last_re; prev_im = last_im;
    wr_coef(2, 1, sh_re[2][1] > 0 ? -100 : 100, 55); commit();
    run_sample("R8", 0, 0);
    for (int b = 0; b < N_BEAM; b++) if (b != 2) begin
      chk("R8", "other beam re unchanged", last_re[b], prev_re[b]);
      chk("R8", "other beam im unchanged", last_im[b], prev_im[b]);
    end
  endtask

  task automatic t_ignore();
    for (int k = 0; k < 3; k++) begin rand_ant(); run_sample("R9", 1, 0); end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; sel_we = 0; sel_slot = 0; sel_ant = 0;
    coef_we = 0; coef_beam = 0; coef_elem = 0; coef_data = 0; coef_commit = 0;
    ant_data = '0;
    for (int s = 0; s < N_ELEM; s++) sel_m[s] = s;
    for (int b = 0; b < N_BEAM; b++)
      for (int e = 0; e < N_ELEM; e++) begin
        sh_re[b][e] = 0; sh_im[b][e] = 0; ac_re[b][e] = 0; ac_im[b][e] = 0;
      end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_extremes();
    t_selector();
    t_shadow();
    t_defer();
    t_beam_indep();
    t_ignore();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule